// File: doc/BRIEF.md
# Frequency-Adaptive Alpha-Beta Delayed Signal Cancellation Stage

This block filters a stationary-frame voltage vector (alpha, beta) by adding to each new sample a copy of the vector from a fraction 1/N of a grid period earlier. Before the sum is halved, that older vector is turned by the constant angle 2π/N. The delay comes from a period estimate supplied at run time. It is given in samples with fractional bits, so the delay follows the grid frequency. When the delay is not a whole number of samples, the block interpolates linearly between the two stored samples on either side of it.

The delay factor N is a parameter. It must be a power of two from 2 to 64. Cascading five copies with N = 32, 16, 8, 4 and 2 in front of a synchronous-frame loop removes the dc offset and all harmonics except orders −31, +33, −63, +65 and the like. The history buffer is sized from the sample rate (8 kHz by default) and the lowest supported grid frequency (40 Hz). That gives FS_HZ/(FMIN_HZ·N) delay samples, which is 100 for N = 2. The nominal 50 Hz period is 160 samples.

Top module: `adsc_stage`

## Requirements
- R1: On each accepted sample the alpha result is floor((A·2^15 + C·Da − S·Db) / 2^16), saturated to the signed DW range. A and B are the present inputs, Da and Db the delayed inputs, and C and S are the Q1.15 constants for cos(2π/N) and sin(2π/N). For N = 2, 4, 8, 16, 32 and 64, C is −32768, 0, 23170, 30274, 32138, 32610 and S is 0, 32767, 23170, 12540, 6393, 3212.
- R2: The beta result is floor((B·2^15 + S·Da + C·Db) / 2^16), saturated the same way.
- R3: `period_i` is the estimated period in samples with FB = 8 fractional bits. The delay is period_i / N, truncated to FB fractional bits. With a whole-sample delay k (k ≥ 1), the delayed value is exactly the sample accepted k samples earlier.
- R4: A delay with integer part k and fraction f/256 gives x0 + floor((x1 − x0)·f / 256). Here x0 is the sample k back, and x1 is the sample k+1 back. For k = 0, x0 is the present input.
- R5: A delay longer than MAXD = FS_HZ/(FMIN_HZ·N) samples is clamped to exactly MAXD samples. MAXD is 12 for N = 16.
- R6: After reset, the first MAXD+1 accepted samples produce alpha and beta results of 0. Every later sample produces the R1/R2 result.
- R7: `valid_o` is high exactly two clock cycles after `valid_i` was high. Results appear in that cycle. `alpha_o` and `beta_o` hold their values while `valid_o` is low. Reset clears all outputs to 0.
- R8: Cycles with `valid_i` low do not enter the history. Delays are counted in accepted samples, not in clock cycles.
- R9: A new `period_i` value applies to the very sample presented with it. The history is not refilled.
- R10: Results beyond the DW range saturate to +32767 or −32768 for DW = 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| alpha_i | input | DW | Alpha component, signed |
| beta_i | input | DW | Beta component, signed |
| period_i | input | PW | Estimated period in samples, FB fractional bits (PW = 16 by default) |
| valid_o | output | 1 | Result strobe |
| alpha_o | output | DW | Filtered alpha, signed |
| beta_o | output | DW | Filtered beta, signed |

## Verification
The hardest states to reach from the ports are at the edges of the circular history. One is the first sample after the buffer has just filled, when the oldest slot is read in the same cycle it is overwritten. Others are the clamped maximum delay and the zero-integer delay, where the present input stands in for a stored sample. The stimulus reaches these states by sweeping `period_i` through values below one sample, across the clamp threshold, and changing on every sample. It also inserts idle cycles so that clock count and sample count diverge. A reference model keeps every accepted sample in a queue and recomputes the interpolation, rotation and saturation each cycle. A constant full-scale vector drives the alpha sum past the signed range.

// File: rtl/adsc_pkg.sv
package adsc_pkg;

  localparam int CW = 16;
  typedef logic signed [CW-1:0] coef_t;

  // Q1.15 cos(2*pi/n), n a power of two in 2..64
  function automatic coef_t rot_cos(input int n);
    case (n)
      2:       return -16'sd32768;
      4:       return 16'sd0;
      8:       return 16'sd23170;
      16:      return 16'sd30274;
      32:      return 16'sd32138;
      64:      return 16'sd32610;
      default: return 16'sd0;
    endcase
  endfunction

  // Q1.15 sin(2*pi/n)
  function automatic coef_t rot_sin(input int n);
    case (n)
      2:       return 16'sd0;
      4:       return 16'sd32767;
      8:       return 16'sd23170;
      16:      return 16'sd12540;
      32:      return 16'sd6393;
      64:      return 16'sd3212;
      default: return 16'sd0;
    endcase
  endfunction

endpackage

// File: rtl/adsc_delay_line.sv
module adsc_delay_line #(
  parameter int DW   = 16,
  parameter int FB   = 8,
  parameter int MAXD = 100,
  localparam int DEPTH = MAXD + 1,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 push_i,
  input  logic signed [DW-1:0] din_i,
  input  logic [AW-1:0]        int_i,
  input  logic [FB-1:0]        frac_i,
  output logic signed [DW-1:0] dout_o
);

  localparam logic [AW+1:0] DEP_X = (AW+2)'(DEPTH);

  logic signed [DW-1:0]    mem_q [DEPTH];
  logic [AW-1:0]           wp_q, rd0, rd1;
  logic [AW+1:0]           wp_x, k0_x, k1_x;
  logic signed [DW-1:0]    x0, x1;
  logic signed [DW:0]      diff;
  logic signed [DW+FB+1:0] prod;

  // newest stored sample sits at wp_q-1; sample k back sits at wp_q-k
  always_comb begin
    wp_x = {2'b00, wp_q};
    k0_x = {2'b00, int_i};
    k1_x = k0_x + (AW+2)'(1);
    rd0  = AW'((wp_x >= k0_x) ? wp_x - k0_x : wp_x + DEP_X - k0_x);
    rd1  = AW'((wp_x >= k1_x) ? wp_x - k1_x : wp_x + DEP_X - k1_x);
    x0   = (int_i == '0) ? din_i : mem_q[rd0];
    x1   = mem_q[rd1];
    diff = {x1[DW-1], x1} - {x0[DW-1], x0};
    prod = diff * $signed({1'b0, frac_i});
    dout_o = x0 + DW'(prod >>> FB);
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wp_q <= '0;
    else if (push_i) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
  end

endmodule

// File: rtl/adsc_rotor.sv
module adsc_rotor import adsc_pkg::*; #(
  parameter int DW = 16,
  parameter int N  = 2
) (
  input  logic signed [DW-1:0] now_a_i,
  input  logic signed [DW-1:0] now_b_i,
  input  logic signed [DW-1:0] del_a_i,
  input  logic signed [DW-1:0] del_b_i,
  output logic signed [DW-1:0] y_a_o,
  output logic signed [DW-1:0] y_b_o
);

  localparam coef_t C    = rot_cos(N);
  localparam coef_t S    = rot_sin(N);
  localparam int    PWID = DW + CW;
  localparam int    ACW  = DW + CW + 2;
  localparam logic signed [ACW-1:0] HI = ACW'((2**(DW-1)) - 1);
  localparam logic signed [ACW-1:0] LO = ~HI;

  logic signed [PWID-1:0] p_ca, p_sb, p_sa, p_cb;
  logic signed [ACW-1:0]  acc_a, acc_b, half_a, half_b;

  function automatic logic signed [DW-1:0] clip(input logic signed [ACW-1:0] v);
    if (v > HI)      return DW'(HI);
    else if (v < LO) return DW'(LO);
    else             return DW'(v);
  endfunction

  always_comb begin
    p_ca   = C * del_a_i;
    p_sb   = S * del_b_i;
    p_sa   = S * del_a_i;
    p_cb   = C * del_b_i;
    // present term scaled to Q15, extra 2^-1 folded into the final shift
    acc_a  = (ACW'(now_a_i) <<< (CW - 1)) + ACW'(p_ca) - ACW'(p_sb);
    acc_b  = (ACW'(now_b_i) <<< (CW - 1)) + ACW'(p_sa) + ACW'(p_cb);
    half_a = acc_a >>> CW;
    half_b = acc_b >>> CW;
    y_a_o  = clip(half_a);
    y_b_o  = clip(half_b);
  end

endmodule

// File: rtl/adsc_stage.sv
module adsc_stage #(
  parameter int DW      = 16,
  parameter int FS_HZ   = 8000,
  parameter int FMIN_HZ = 40,
  parameter int N       = 2,
  parameter int FB      = 8,
  localparam int PW     = $clog2(FS_HZ / FMIN_HZ + 1) + FB
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [DW-1:0] alpha_i,
  input  logic signed [DW-1:0] beta_i,
  input  logic [PW-1:0]        period_i,
  output logic                 valid_o,
  output logic signed [DW-1:0] alpha_o,
  output logic signed [DW-1:0] beta_o
);

  localparam int MAXD  = FS_HZ / (FMIN_HZ * N);
  localparam int DEPTH = MAXD + 1;
  localparam int KW    = $clog2(DEPTH);
  localparam int SH    = $clog2(N);
  localparam int CNTW  = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] MAXFX = PW'(MAXD * (2**FB));

  logic [PW-1:0]        dly_fx, dly_cl;
  logic [KW-1:0]        dly_int;
  logic [FB-1:0]        dly_frac;
  logic [CNTW-1:0]      fill_q;
  logic                 primed;
  logic                 v1_q;
  logic signed [DW-1:0] rot_a, rot_b;

  // N is a power of two: divide by shifting
  always_comb begin
    dly_fx   = period_i >> SH;
    dly_cl   = (dly_fx > MAXFX) ? MAXFX : dly_fx;
    dly_int  = KW'(dly_cl >> FB);
    dly_frac = dly_cl[FB-1:0];
  end

  assign primed = (fill_q == CNTW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                fill_q <= '0;
    else if (valid_i && !primed) fill_q <= fill_q + CNTW'(1);
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic signed [DW-1:0] din, dout, now_q, del_q;

    assign din = (g == 0) ? alpha_i : beta_i;

    adsc_delay_line #(
      .DW  (DW),
      .FB  (FB),
      .MAXD(MAXD)
    ) u_dl (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .push_i(valid_i),
      .din_i (din),
      .int_i (dly_int),
      .frac_i(dly_frac),
      .dout_o(dout)
    );

    // until the history is full both terms are forced to zero
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        now_q <= '0;
        del_q <= '0;
      end else if (valid_i) begin
        now_q <= primed ? din  : '0;
        del_q <= primed ? dout : '0;
      end
    end
  end

  adsc_rotor #(
    .DW(DW),
    .N (N)
  ) u_rot (
    .now_a_i(g_lane[0].now_q),
    .now_b_i(g_lane[1].now_q),
    .del_a_i(g_lane[0].del_q),
    .del_b_i(g_lane[1].del_q),
    .y_a_o  (rot_a),
    .y_b_o  (rot_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q    <= 1'b0;
      valid_o <= 1'b0;
      alpha_o <= '0;
      beta_o  <= '0;
    end else begin
      v1_q    <= valid_i;
      valid_o <= v1_q;
      if (v1_q) begin
        alpha_o <= rot_a;
        beta_o  <= rot_b;
      end
    end
  end

endmodule

// File: rtl/adsc_stage_chk.sv
module adsc_stage_chk #(
  parameter int DW    = 16,
  parameter int DEPTH = 101
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic                 valid_o,
  input logic signed [DW-1:0] alpha_o,
  input logic signed [DW-1:0] beta_o
);

  localparam int CNTW = $clog2(DEPTH + 1);

  logic [CNTW-1:0] out_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    out_cnt_q <= '0;
    else if (valid_o && out_cnt_q != CNTW'(DEPTH)) out_cnt_q <= out_cnt_q + CNTW'(1);
  end

  // R7
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ##1 valid_o);

  // R7
  valid_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ##1 !valid_o);

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(alpha_o) && $stable(beta_o)));

  // R6
  prefill_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && out_cnt_q < CNTW'(DEPTH)) |-> (alpha_o == '0 && beta_o == '0));

endmodule

bind adsc_stage adsc_stage_chk #(
  .DW   (DW),
  .DEPTH(DEPTH)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .valid_o(valid_o),
  .alpha_o(alpha_o),
  .beta_o (beta_o)
);

// File: tb/adsc_stage_test.sv
`timescale 1ns/1ps
module adsc_stage_test;

  localparam int DW   = 16;
  localparam int PW   = 16;
  localparam int NF   = 16;
  localparam int MAXD = 12;
  localparam int DEP  = MAXD + 1;
  localparam longint CQ = 30274;
  localparam longint SQ = 12540;

  logic                 clk = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 valid_i = 1'b0;
  logic signed [DW-1:0] alpha_i = '0;
  logic signed [DW-1:0] beta_i = '0;
  logic [PW-1:0]        period_i = '0;
  logic                 valid_o;
  logic signed [DW-1:0] alpha_o;
  logic signed [DW-1:0] beta_o;

  always #2.5 clk = ~clk;

  adsc_stage #(.DW(DW), .N(NF)) uut (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .alpha_i (alpha_i),
    .beta_i  (beta_i),
    .period_i(period_i),
    .valid_o (valid_o),
    .alpha_o (alpha_o),
    .beta_o  (beta_o)
  );

  int    checks = 0;
  int    fails = 0;
  bit    ended = 0;
  string req = "R6";

  int ha[$];
  int hb[$];
  bit ev1 = 0, evo = 0;
  int r1a = 0, r1b = 0, eoa = 0, eob = 0;

  function automatic int sat16(longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  // R4 linear interpolation, floor rounding
  function automatic int lerp(int x0, int x1, int f);
    return x0 + (((x1 - x0) * f) >>> 8);
  endfunction

  task automatic model(bit v, int a, int b, int p);
    evo = ev1;
    if (ev1) begin
      eoa = r1a;
      eob = r1b;
    end
    ev1 = v;
    if (v) begin
      int t = ha.size();
      if (t < DEP) begin
        r1a = 0;
        r1b = 0;
      end else begin
        int dfx = p >> 4;
        int k, f, da, db;
        longint acc;
        if (dfx > MAXD * 256) dfx = MAXD * 256;
        k  = dfx >> 8;
        f  = dfx & 255;
        da = lerp((k == 0) ? a : ha[t-k], ha[t-k-1], f);
        db = lerp((k == 0) ? b : hb[t-k], hb[t-k-1], f);
        acc = longint'(a) * 32768 + CQ * longint'(da) - SQ * longint'(db);
        r1a = sat16(acc >>> 16);
        acc = longint'(b) * 32768 + SQ * longint'(da) + CQ * longint'(db);
        r1b = sat16(acc >>> 16);
      end
      ha.push_back(a);
      hb.push_back(b);
    end
  endtask

  task automatic compare();
    checks++;
    if (valid_o !== evo) begin
      fails++;
      $display("FAIL R7 [%s] valid_o=%0d expected %0d", req, valid_o, evo);
    end
    checks++;
    if (int'(alpha_o) != eoa) begin
      fails++;
      $display("FAIL R1 [%s] alpha_o=%0d expected %0d", req, alpha_o, eoa);
    end
    checks++;
    if (int'(beta_o) != eob) begin
      fails++;
      $display("FAIL R2 [%s] beta_o=%0d expected %0d", req, beta_o, eob);
    end
  endtask

  task automatic cyc(bit v, int a, int b, int p);
    valid_i  = v;
    alpha_i  = DW'(a);
    beta_i   = DW'(b);
    period_i = PW'(p);
    @(posedge clk);
    model(v, a, b, p);
    @(negedge clk);
    compare();
  endtask

  function automatic int rnd();
    return int'($urandom_range(0, 32000)) - 16000;
  endfunction

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #500000;
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state, R7
    req = "R7";
    compare();
    rst_ni = 1'b1;

    // R6 and R8: prefill with idle gaps, all results zero
    req = "R6";
    for (int i = 0; i < DEP; i++) begin
      cyc(1, 1000 * i - 5000, 7000 - 700 * i, 40960);
      req = "R8";
      cyc(0, 12345, -999, 40960);
      req = "R6";
    end

    // R3 whole-sample delay of 10
    req = "R3";
    for (int i = 0; i < 40; i++) cyc(1, rnd(), rnd(), 40960);

    // R4 fractional delays
    req = "R4";
    for (int i = 0; i < 30; i++) cyc(1, rnd(), rnd(), 43000);
    for (int i = 0; i < 30; i++) cyc(1, rnd(), rnd(), 41100);
    for (int i = 0; i < 20; i++) cyc(1, rnd(), rnd(), 100 + 37 * i);

    // R5 clamp at MAXD
    req = "R5";
    for (int i = 0; i < 20; i++) cyc(1, rnd(), rnd(), 60000);
    for (int i = 0; i < 20; i++) cyc(1, rnd(), rnd(), 49152);
    for (int i = 0; i < 20; i++) cyc(1, rnd(), rnd(), 65535);

    // R9 period changes every sample, incl. sub-sample delays
    req = "R9";
    for (int i = 0; i < 60; i++) cyc(1, rnd(), rnd(), (i * 4099 + 53) % 65536);

    // R10 saturation with full-scale vector
    req = "R10";
    for (int i = 0; i < 20; i++) cyc(1, 32767, -32768, 40960);
    for (int i = 0; i < 20; i++) cyc(1, -32768, 32767, 40960);

    // R8 / R7 irregular strobes
    req = "R8";
    for (int i = 0; i < 200; i++)
      cyc(bit'($urandom_range(0, 2) != 0), rnd(), rnd(), 38000 + int'($urandom_range(0, 8000)));

    req = "R7";
    for (int i = 0; i < 4; i++) cyc(0, rnd(), rnd(), 40960);

    finish_run();
  end

endmodule